// File: doc/BRIEF.md
# Heartbeat Failover Monitor

This block sits on the standby side of a redundant host pair and watches for the periodic "alive" signal sent by the active host. Each heartbeat arrives as a single-cycle pulse, for example a doorbell bit that has been decoded to a strobe. A separate tick marks the end of each expected heartbeat interval. At every tick the monitor decides whether the interval that just closed saw at least one heartbeat. It keeps a running count of consecutive intervals that had none.

When that count reaches a programmable threshold, the monitor declares the active host dead. It raises a failure flag and a takeover request. Both stay high until standby software acknowledges them. A threshold of zero turns detection off. An enable input lets software park the monitor, for example while the active host is still booting.

Top module: `hb_failover_mon`

## Requirements
- R1: After reset, `failed`, `takeover_req` and `miss_count` are all zero.
- R2: At an enabled tick that closes an interval with at least one heartbeat, `miss_count` becomes 0 after that clock edge.
- R3: A heartbeat in the same cycle as a tick counts toward the interval that is closing. The next interval starts with no heartbeat recorded.
- R4: At an enabled tick that closes an interval with no heartbeat, `miss_count` increases by one. It saturates at 2^CNT_W-1 and does not wrap.
- R5: While `enable` is low, `miss_count` is 0 after each clock edge, no heartbeat is remembered, and no new failure is declared.
- R6: At the enabled tick where the updated miss count becomes greater than or equal to a non-zero `miss_thresh`, `failed` and `takeover_req` both go high after that edge.
- R7: When `miss_thresh` is 0, no failure is ever declared, however many intervals are missed.
- R8: `failed` and `takeover_req` stay high until `takeover_ack` is sampled high. Both are then low after that edge. If a new failure is declared in the same cycle as the acknowledge, the failure wins.
- R9: Several heartbeats within one interval have the same effect as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Monitor enable; low holds the count at zero |
| hb_pulse | input | 1 | Single-cycle heartbeat strobe from the active host |
| period_tick | input | 1 | Single-cycle strobe that closes an expected heartbeat interval |
| miss_thresh | input | CNT_W | Consecutive missed intervals that declare failure; 0 disables detection |
| takeover_ack | input | 1 | Software acknowledge; clears the failure flag and the request |
| failed | output | 1 | Sticky flag: active host declared dead |
| takeover_req | output | 1 | Sticky request for the standby host to take control |
| miss_count | output | CNT_W | Current run of consecutive missed intervals |

## Verification
The bench sweeps every threshold of a small configuration. Stimulus comes from a pseudo-random pattern of heartbeats, ticks, enable drops and acknowledges, checked against an arithmetic model on every cycle.

Directed cases target specific faults:
- A heartbeat coinciding with a tick. A design that credits it to the next interval would miss once too often and declare failure early.
- A threshold of zero. A design that compares with `>=` unguarded would fail at the first miss.
- The maximum threshold with heartbeats absent indefinitely. A wrapping counter would never reach the threshold, or would restart the run.
- An acknowledge in the same cycle as a new declaration. A design that lets the acknowledge win would silently lose a failure.

// File: rtl/hb_mon_pkg.sv
package hb_mon_pkg;

  // Outcome of one cycle as seen by the interval tracker
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,   // no interval closed this cycle
    VERD_HIT  = 2'd1,   // interval closed, heartbeat seen
    VERD_MISS = 2'd2    // interval closed, no heartbeat
  } verdict_e;

endpackage

// File: rtl/hb_period_tracker.sv
module hb_period_tracker
  import hb_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     hb_pulse,
  input  logic     period_tick,
  output verdict_e verdict
);

  logic seen_q;
  logic seen_now;   // heartbeat seen in the open interval, this cycle included

  assign seen_now = seen_q | hb_pulse;

  always_comb begin
    if (!enable || !period_tick) verdict = VERD_NONE;
    else if (seen_now)           verdict = VERD_HIT;
    else                         verdict = VERD_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           seen_q <= 1'b0;
    else if (!enable)     seen_q <= 1'b0;
    else if (period_tick) seen_q <= 1'b0;
    else                  seen_q <= seen_now;
  end

  // R3: a closing tick always starts the next interval empty
  a_r3_tick_empties: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !seen_q);

  // R9: a heartbeat inside an interval is remembered until the tick
  a_r9_hb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hb_pulse && !period_tick) |=> seen_q);

  // R5: nothing is remembered while disabled
  a_r5_no_memory_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !seen_q);

endmodule

// File: rtl/hb_miss_counter.sv
module hb_miss_counter
  import hb_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  verdict_e         verdict,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    if (!enable)                     cnt_next = '0;
    else if (verdict == VERD_HIT)    cnt_next = '0;
    else if (verdict == VERD_MISS)   cnt_next = sat_inc(cnt_q);
    else                             cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  // R2: a closed interval with a heartbeat zeroes the run
  a_r2_hit_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VERD_HIT) |=> (cnt_q == '0));

  // R4: a miss below the ceiling adds exactly one
  a_r4_miss_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VERD_MISS && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: at the ceiling the count stays put
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VERD_MISS && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R5: disabled holds the count at zero
  a_r5_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

endmodule

// File: rtl/hb_fail_latch.sv
module hb_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic ack,
  output logic failed_q,
  output logic req_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      failed_q <= 1'b0;
      req_q    <= 1'b0;
    end else if (set_ev) begin
      failed_q <= 1'b1;
      req_q    <= 1'b1;
    end else if (ack) begin
      failed_q <= 1'b0;
      req_q    <= 1'b0;
    end
  end

  // R8: sticky without an acknowledge
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (failed_q && !ack) |=> failed_q);

  // R8: acknowledge clears both outputs unless a new failure arrives
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_ev) |=> (!failed_q && !req_q));

  // R8: a declaration beats a simultaneous acknowledge
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> (failed_q && req_q));

endmodule

// File: rtl/hb_failover_mon.sv
module hb_failover_mon
  import hb_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hb_pulse,
  input  logic             period_tick,
  input  logic [CNT_W-1:0] miss_thresh,
  input  logic             takeover_ack,
  output logic             failed,
  output logic             takeover_req,
  output logic [CNT_W-1:0] miss_count
);

  verdict_e         verdict;
  logic [CNT_W-1:0] cnt_next;
  logic             trip;     // failure declared this cycle

  function automatic logic trips(input verdict_e v,
                                 input logic [CNT_W-1:0] next_cnt,
                                 input logic [CNT_W-1:0] thr);
    return (v == VERD_MISS) && (thr != '0) && (next_cnt >= thr);
  endfunction

  hb_period_tracker u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .hb_pulse    (hb_pulse),
    .period_tick (period_tick),
    .verdict     (verdict)
  );

  hb_miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .verdict  (verdict),
    .cnt_q    (miss_count),
    .cnt_next (cnt_next)
  );

  assign trip = trips(verdict, cnt_next, miss_thresh);

  hb_fail_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   (trip),
    .ack      (takeover_ack),
    .failed_q (failed),
    .req_q    (takeover_req)
  );

  // R7: zero threshold never raises a fresh failure
  a_r7_zero_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_thresh == '0 && !failed) |=> !failed);

  // R5: no new failure while disabled
  a_r5_no_decl_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !failed) |=> !failed);

  // R6: flag and request move together
  a_r6_outputs_paired: assert property (@(posedge clk) disable iff (!rst_n)
    failed == takeover_req);

  // R6: a rise of the flag only follows a closing miss
  a_r6_rise_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (!failed && verdict != VERD_MISS) |=> !failed);

endmodule

// File: tb/sim_hb_failover_mon.sv
module sim_hb_failover_mon;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic enable = 0, hb = 0, tick = 0, ack = 0;
  logic [W-1:0] thr = '0;
  logic failed, req;
  logic [W-1:0] cnt;

  int n_run = 0, n_fail = 0, cyc = 0;
  int m_cnt = 0; bit m_seen = 0, m_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  hb_failover_mon #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hb_pulse(hb),
    .period_tick(tick), .miss_thresh(thr), .takeover_ack(ack),
    .failed(failed), .takeover_req(req), .miss_count(cnt));

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual running expected done");
      report();
    end
  end

  task automatic check(string tag);
    n_run++;
    if (cnt !== W'(m_cnt) || failed !== m_fail || req !== m_fail) begin
      n_fail++;
      $display("FAIL %s: actual cnt=%0d failed=%b req=%b expected cnt=%0d failed=%b req=%b",
               tag, cnt, failed, req, m_cnt, m_fail, m_fail);
    end
  endtask

  // One clock: apply inputs, advance model, compare after the edge
  task automatic step(bit e, bit h, bit t, bit a, string tag);
    bit had, set;
    enable = e; hb = h; tick = t; ack = a;
    had = m_seen | h;
    set = 0;
    if (!e) begin m_cnt = 0; m_seen = 0; end
    else if (t) begin
      int nx;
      nx = had ? 0 : ((m_cnt == MAX) ? MAX : m_cnt + 1);
      set = !had && (thr != 0) && (nx >= int'(thr));
      m_cnt = nx; m_seen = 0;
    end else m_seen = had;
    if (set) m_fail = 1; else if (a) m_fail = 0;
    @(posedge clk); #2;
    check(tag);
  endtask

  task automatic do_reset;
    rst_n = 0; enable = 0; hb = 0; tick = 0; ack = 0;
    repeat (2) @(posedge clk);
    #2; rst_n = 1;
    m_cnt = 0; m_seen = 0; m_fail = 0;
  endtask

  initial begin
    do_reset();
    check("R1");
    thr = 4'd2;
    // R2: heartbeat mid interval, then tick
    step(1,0,1,0,"R4"); step(1,1,0,0,"R9"); step(1,1,0,0,"R9");
    step(1,0,1,0,"R2");
    // R3: heartbeat on the tick, then empty interval counts as miss
    step(1,0,1,0,"R4"); step(1,1,1,0,"R3"); step(1,0,1,0,"R3");
    // R6: second consecutive miss declares
    step(1,0,1,0,"R6"); step(1,0,0,0,"R8"); step(1,1,1,0,"R8");
    step(1,0,0,1,"R8");
    // R8: ack on the same cycle as a declaration
    step(1,0,1,0,"R4"); step(1,0,1,1,"R8");
    step(1,0,0,1,"R8");
    // R5: disable clears count and seen, no declaration
    step(1,0,1,0,"R4"); step(0,0,1,0,"R5"); step(1,1,0,0,"R5");
    step(0,0,0,0,"R5"); step(1,0,1,0,"R5"); step(0,0,1,0,"R5");
    // R7: zero threshold, many misses
    thr = 0;
    for (int i = 0; i < 20; i++) step(1,0,1,0,"R7");
    // R4: saturation at max threshold
    thr = W'(MAX);
    step(0,0,0,0,"R5");
    for (int i = 0; i < 20; i++) step(1,0,1,0,"R4");
    step(1,0,0,1,"R8");
    step(1,0,1,0,"R4");
    // Sweep all thresholds with a pseudo-random pattern
    for (int t = 0; t <= MAX; t++) begin
      do_reset();
      thr = W'(t);
      for (int i = 0; i < 400; i++) begin
        bit e, h, k, a;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        e = (lfsr[3:0] != 4'd0);
        h = (lfsr[7:5] == 3'd0);
        k = (i % 3 == 0);
        a = (lfsr[11:9] == 3'd7);
        step(e, h, k, a, (t == 0) ? "R7" : "R6");
      end
    end
    report();
  end
endmodule